// File: doc/BRIEF.md
# Delayed Chip Reset Generator

This block keeps the internal chip reset asserted after power-up and after every master-clear event, and lets it go only once a programmable number of ticks from a slow internal oscillator has elapsed. The block has a reset latch and a delay counter. Power-up sets the latch and clears the counter. The counter advances only while the master-clear level is high. When it reaches the terminal count, it clears the latch, and that ends the chip reset.

A configuration input can disable the master-clear pin. The level is then treated as permanently high inside the block, so the delay starts straight after power-up. A low master-clear level at any time sets the latch again and zeroes the counter. The delay then starts over once the level returns high. The terminal count is an input of parameter width. A system can program the full delay of roughly 18 ms of oscillator ticks, and a simulation can program a few ticks.

Top module: `dly_reset_timer`

## Requirements
- R1: While the synchronous power-on input `rst` is high, `chip_rst` is 1 from the following clock edge, and the delay count is zero when `rst` falls.
- R2: With `mclr_disable`=0 and `mclr_pin`=0, `chip_rst` stays 1 no matter how many oscillator ticks arrive.
- R3: With the effective master-clear level high, `chip_rst` goes to 0 at the clock edge that samples the N-th `osc_tick`=1 since the count was last cleared, N being `term_count`. The bench reads it one cycle after that edge.
- R4: Clock cycles with `osc_tick`=0 do not advance the delay. A gap of any length between ticks leaves the release point unchanged in tick count.
- R5: With `mclr_disable`=1 the pin value is ignored and the level counts as high, so the delay starts right after power-on even when `mclr_pin` is 0.
- R6: An effective master-clear level of 0 in any cycle sets `chip_rst` to 1 at the next edge and restarts the delay from zero. This holds both during counting and after release.
- R7: When the effective level is 0 in the same cycle as the tick that would complete the delay, master-clear wins: `chip_rst` stays 1 and the count restarts from zero.
- R8: A `term_count` of 0 or 1 releases the reset at the first tick.
- R9: Once released, `chip_rst` stays 0 while the effective level stays high, whatever the ticks and changes of `term_count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mclr_pin | input | 1 | Master-clear pin level; 0 requests reset |
| mclr_disable | input | 1 | Configuration: 1 ignores the pin and ties the level high |
| osc_tick | input | 1 | One-cycle tick from the internal delay oscillator |
| term_count | input | CNT_W | Number of ticks in the reset delay |
| chip_rst | output | 1 | Internal chip reset, active high |

## Verification
The counter's final tick can land in the same cycle as a master-clear drop. The release and the re-arm then compete for the latch. The bench provokes this by holding the pin low in exactly the cycle of the terminal tick. It expects the reset to stay asserted and a full fresh delay to follow once the pin returns high. It also places a master-clear drop in the same cycle as a gap in the ticks, and a pin pulse after release. A behavioural model in the bench compares each case cycle by cycle.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic {
        ST_HELD     = 1'b1,
        ST_RELEASED = 1'b0
    } rst_state_e;

    typedef struct packed {
        logic clear;
        logic advance;
    } cnt_ctl_t;

    function automatic cnt_ctl_t make_ctl(input logic level, input logic held, input logic tick);
        cnt_ctl_t c;
        c.clear   = ~level;
        c.advance = level & held & tick;
        return c;
    endfunction

endpackage

// File: rtl/drt_mclr_select.sv
module drt_mclr_select #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic mclr_pin,
    input  logic mclr_disable,
    output logic mclr_level
);
    logic raw_level;
    assign raw_level = mclr_disable | mclr_pin;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign mclr_level = raw_level;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_level};
            end
            assign mclr_level = sync_q[SYNC_STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/drt_counter.sv
module drt_counter
    import drt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] term_count,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;
    logic [EXT_W-1:0] next_ext;

    assign next_ext = {1'b0, count} + EXT_W'(1);
    assign expire   = ctl.advance && (next_ext >= {1'b0, term_count});

    always_ff @(posedge clk) begin
        if (rst || ctl.clear)            count <= '0;
        else if (ctl.advance && !expire) count <= next_ext[CNT_W-1:0];
    end
endmodule

// File: rtl/drt_latch.sv
module drt_latch
    import drt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic held
);
    rst_state_e state;

    always_ff @(posedge clk) begin
        if (rst || set_req) state <= ST_HELD;
        else if (clr_req)   state <= ST_RELEASED;
    end

    assign held = (state == ST_HELD);
endmodule

// File: rtl/dly_reset_timer.sv
module dly_reset_timer
    import drt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclr_pin,
    input  logic             mclr_disable,
    input  logic             osc_tick,
    input  logic [CNT_W-1:0] term_count,
    output logic             chip_rst
);
    logic             mclr_level;
    logic             held;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;
    cnt_ctl_t         ctl;

    drt_mclr_select #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk(clk), .rst(rst), .mclr_pin(mclr_pin),
        .mclr_disable(mclr_disable), .mclr_level(mclr_level)
    );

    assign ctl = make_ctl(mclr_level, held, osc_tick);

    drt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ctl(ctl), .term_count(term_count),
        .count(cnt_q), .expire(expire)
    );

    drt_latch u_latch (
        .clk(clk), .rst(rst), .set_req(ctl.clear),
        .clr_req(expire), .held(held)
    );

    assign chip_rst = held;
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mclr_level,
    input logic             osc_tick,
    input logic             chip_rst,
    input logic [CNT_W-1:0] count
);
    AST_LOW_MCLR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !mclr_level |=> chip_rst); // R6
    AST_LOW_MCLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        !mclr_level |=> (count == '0)); // R7
    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (chip_rst && !osc_tick) |=> chip_rst); // R4
    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (rst)
        (chip_rst && !osc_tick && mclr_level) |=> $stable(count)); // R4
    AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!chip_rst && mclr_level) |=> !chip_rst); // R9
    AST_RELEASE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst) |-> $past(osc_tick && mclr_level)); // R3
endmodule

bind dly_reset_timer drt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .mclr_level(mclr_level), .osc_tick(osc_tick),
    .chip_rst(chip_rst), .count(cnt_q)
);

// File: tb/dly_reset_timer_tb.sv
`timescale 1ns/1ps
module dly_reset_timer_tb;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mclr_pin = 1'b0;
    logic             mclr_disable = 1'b0;
    logic             osc_tick = 1'b0;
    logic [CNT_W-1:0] term_count = 8'd6;
    logic             chip_rst;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference
    bit m_held = 1'b1;
    int m_cnt = 0;

    dly_reset_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .mclr_pin(mclr_pin), .mclr_disable(mclr_disable),
        .osc_tick(osc_tick), .term_count(term_count), .chip_rst(chip_rst)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (rst || !(mclr_pin || mclr_disable)) begin
            m_held = 1'b1;
            m_cnt  = 0;
        end else if (m_held && osc_tick) begin
            if (m_cnt + 1 >= int'(term_count)) m_held = 1'b0;
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: chip_rst=%0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cyc > 0) check(cur_req, chip_rst, m_held);
    end

    task automatic step(input logic tick);
        @(negedge clk);
        osc_tick = tick;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; osc_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // counts ticks until release; returns -1 on no release
    task automatic ticks_to_release(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            step(1'b1);
            @(posedge clk); #1;
            if (chip_rst === 1'b0) begin n = i; break; end
        end
        @(negedge clk); osc_tick = 1'b0;
    endtask

    initial begin : main
        int n;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check("R1", chip_rst, 1'b1);
        rst = 1'b0;

        // R2: pin low, many ticks
        cur_req = "R2";
        for (int i = 0; i < 20; i++) step(1'b1);
        step(1'b0);
        check("R2", chip_rst, 1'b1);

        // R3: pin high, six ticks release
        cur_req = "R3";
        @(negedge clk); mclr_pin = 1'b1;
        ticks_to_release(50, n);
        n_chk++;
        if (n != 6) begin n_bad++; $display("FAIL R3: release after %0d ticks expected 6", n); end

        // R9: after release, ticks and term changes do nothing
        cur_req = "R9";
        for (int i = 0; i < 10; i++) begin step(1'b1); term_count = 8'(i * 37); end
        step(1'b0);
        term_count = 8'd6;
        check("R9", chip_rst, 1'b0);

        // R6: pulse low after release, then mid-count
        cur_req = "R6";
        @(negedge clk); mclr_pin = 1'b0;
        @(negedge clk); mclr_pin = 1'b1;
        check("R6", chip_rst, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1);
        step(1'b1); mclr_pin = 1'b0;
        step(1'b0); mclr_pin = 1'b1;
        ticks_to_release(50, n);
        n_chk++;
        if (n != 6) begin n_bad++; $display("FAIL R6: restart gave %0d ticks expected 6", n); end

        // R4: sparse ticks
        cur_req = "R4";
        do_reset();
        for (int t = 0; t < 5; t++) begin
            step(1'b1);
            repeat (3) step(1'b0);
        end
        check("R4", chip_rst, 1'b1);
        step(1'b1);
        step(1'b0);
        check("R4", chip_rst, 1'b0);

        // R7: terminal tick collides with master-clear drop
        cur_req = "R7";
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1);
        step(1'b1); mclr_pin = 1'b0;
        step(1'b0); mclr_pin = 1'b1;
        check("R7", chip_rst, 1'b1);
        ticks_to_release(50, n);
        n_chk++;
        if (n != 6) begin n_bad++; $display("FAIL R7: after collision %0d ticks expected 6", n); end

        // R5: pin disabled by configuration
        cur_req = "R5";
        mclr_pin = 1'b0; mclr_disable = 1'b1;
        do_reset();
        step(1'b0);
        check("R5", chip_rst, 1'b1);
        ticks_to_release(50, n);
        n_chk++;
        if (n != 6) begin n_bad++; $display("FAIL R5: tied level gave %0d ticks expected 6", n); end
        mclr_disable = 1'b0; mclr_pin = 1'b1;

        // R8: terminal counts of 0 and 1
        cur_req = "R8";
        for (int tc = 0; tc < 2; tc++) begin
            term_count = 8'(tc);
            do_reset();
            step(1'b0);
            check("R8", chip_rst, 1'b1);
            ticks_to_release(10, n);
            n_chk++;
            if (n != 1) begin n_bad++; $display("FAIL R8: term %0d gave %0d ticks expected 1", tc, n); end
        end

        // R3: longer delay
        cur_req = "R3";
        term_count = 8'd200;
        do_reset();
        ticks_to_release(300, n);
        n_chk++;
        if (n != 200) begin n_bad++; $display("FAIL R3: long delay %0d ticks expected 200", n); end

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule